// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a set of 75 peripheral request lines and the channel engines of a DMA controller. Each request line owns an 8-bit map entry that names a target channel and carries a valid flag. The block synchronises every request input, detects its edges, and forwards them to the mapped channel. The channel sees three outputs: a request level, a one-cycle pulse when its request becomes active (request-after-stop), and a one-cycle pulse when its request becomes inactive (end-of-receive).

Software programs the map entries through a simple byte-wide register port. Entries 0 to 63 occupy one word-spaced window and entries 64 to 74 a second window. An entry that names a channel the block does not have is refused and an error pulse is raised. When several requests share a channel, the channel level follows whichever of them changed most recently. Within one clock cycle, the highest-numbered changing request wins.

Top module: `dreq_chan_map`

## Requirements
- R1: After reset every map entry reads 0, and `ch_req`, `ch_ras`, `ch_eor` and `map_err` are all 0.
- R2: Entry k (k < 64) is at byte address 0x100 + 4k. Entry k (64 <= k < 75) is at 0x1100 + 4(k-64). `rdata` shows the addressed entry combinationally. Any other address reads 0, and a write to it changes no entry.
- R3: In a map entry, bits 4:0 hold the target channel and bit 7 is the valid flag. Bits 6:5 are stored and read back unchanged.
- R4: A request whose entry has bit 7 clear has no effect on any channel output.
- R5: A rising edge on a request input updates the mapped channel on the third rising clock edge after the input changes. At that edge `ch_req` goes to 1 and `ch_ras` is 1 for exactly one cycle, provided `ch_req` was 0.
- R6: A falling request sets the channel's `ch_req` to 0 on that same third edge. If `ch_req` was 1, `ch_eor` is 1 for one cycle.
- R7: The channel level follows the latest edge from any request mapped to it. An edge that leaves the level unchanged produces no pulse, and `ch_ras` and `ch_eor` are never high together.
- R8: When several requests mapped to one channel change in the same cycle, the highest-numbered request decides the new level.
- R9: A write with bit 7 set and a channel field >= NUM_CH to a valid entry address leaves the entry unchanged. In that case `map_err` is 1 for exactly the cycle after the write edge; otherwise `map_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the map entry at `addr` |
| addr | input | 13 | Byte address for reads and writes |
| wdata | input | 8 | Map entry write data |
| rdata | output | 8 | Map entry at `addr`, 0 when unmapped |
| map_err | output | 1 | Pulse: refused write of an out-of-range channel |
| req_in | input | NUM_REQ | Asynchronous peripheral request lines |
| ch_req | output | NUM_CH | Per-channel request level |
| ch_ras | output | NUM_CH | Per-channel request-after-stop pulse |
| ch_eor | output | NUM_CH | Per-channel end-of-receive pulse |

## Verification
The bench aims at shared channels. If a second request rises while the channel is already high, a design that pulses on every raw edge would emit a false request-after-stop. It also makes opposite-direction edges on one channel land in the same cycle; a design that resolves toward the lowest index would leave the wrong level. Entries with the valid bit clear are toggled hard, so a design that ignores the flag drives a channel it should not touch. Out-of-range channel writes and both address windows are exercised, which catches a design that stores bad entries or decodes the upper window with the wrong offset. Latency is checked one edge early as well as on time, so a missing or extra synchroniser stage shows up.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    localparam int ADDR_W     = 13;
    localparam int MAP_W      = 8;
    localparam int LOW_COUNT  = 64;
    localparam int LOW_BASE   = 'h100;
    localparam int HIGH_BASE  = 'h1100;

    // Entry layout: bit 7 valid, bits 6:5 spare, bits 4:0 channel.
    typedef struct packed {
        logic       valid;
        logic [1:0] spare;
        logic [4:0] chan;
    } map_entry_t;

    typedef struct packed {
        logic       hit;
        logic [6:0] idx;
    } decode_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a, input int num_req);
        decode_t d;
        int      ia;
        d  = '0;
        ia = int'(a);
        if (a[1:0] == 2'b00) begin
            if (ia >= LOW_BASE && ia < LOW_BASE + 4 * LOW_COUNT) begin
                d.hit = 1'b1;
                d.idx = 7'((ia - LOW_BASE) / 4);
            end else if (ia >= HIGH_BASE && ia < HIGH_BASE + 4 * (num_req - LOW_COUNT)) begin
                d.hit = 1'b1;
                d.idx = 7'(LOW_COUNT + (ia - HIGH_BASE) / 4);
            end
        end
        return d;
    endfunction

    function automatic logic chan_out_of_range(input map_entry_t e, input int num_ch);
        return e.valid && (int'(e.chan) >= num_ch);
    endfunction

endpackage

// File: rtl/dcm_sync.sv
module dcm_sync #(
    parameter int NUM_REQ = 75
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req_in,
    output logic [NUM_REQ-1:0] lvl,
    output logic [NUM_REQ-1:0] chg
);
    logic [NUM_REQ-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= req_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl = sync_q;
    assign chg = sync_q ^ prev_q;
endmodule

// File: rtl/dcm_regs.sv
module dcm_regs
    import dcm_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [MAP_W-1:0]           wdata,
    output logic [MAP_W-1:0]           rdata,
    output logic                       map_err,
    output map_entry_t [NUM_REQ-1:0]   map_out
);
    decode_t    dec;
    map_entry_t wr_ent;
    logic       wr_bad, wr_ok;

    always_comb begin
        dec    = decode_addr(addr, NUM_REQ);
        wr_ent = map_entry_t'(wdata);
        wr_bad = wr_en && dec.hit && chan_out_of_range(wr_ent, NUM_CH);
        wr_ok  = wr_en && dec.hit && !wr_bad;
    end

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_entry
        map_entry_t ent_q;
        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= '0;
            else if (wr_ok && (dec.idx == 7'(i)))
                ent_q <= wr_ent;
        end
        assign map_out[i] = ent_q;
    end

    always_ff @(posedge clk) begin
        if (rst) map_err <= 1'b0;
        else     map_err <= wr_bad;
    end

    assign rdata = dec.hit ? MAP_W'(map_out[dec.idx]) : '0;
endmodule

// File: rtl/dcm_route.sv
module dcm_route
    import dcm_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  map_entry_t [NUM_REQ-1:0]  map_in,
    input  logic [NUM_REQ-1:0]        lvl,
    input  logic [NUM_REQ-1:0]        chg,
    output logic [NUM_CH-1:0]         ch_req,
    output logic [NUM_CH-1:0]         ch_ras,
    output logic [NUM_CH-1:0]         ch_eor
);
    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0] hit_c, val_c;

    // Ascending scan: the highest-numbered changing request is the last writer.
    always_comb begin
        hit_c = '0;
        val_c = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (chg[i] && map_in[i].valid && (int'(map_in[i].chan) < NUM_CH)) begin
                hit_c[CH_IDX_W'(map_in[i].chan)] = 1'b1;
                val_c[CH_IDX_W'(map_in[i].chan)] = lvl[i];
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic lvl_q, ras_q, eor_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q <= 1'b0;
                ras_q <= 1'b0;
                eor_q <= 1'b0;
            end else begin
                lvl_q <= hit_c[c] ? val_c[c] : lvl_q;
                ras_q <= hit_c[c] &&  val_c[c] && !lvl_q;
                eor_q <= hit_c[c] && !val_c[c] &&  lvl_q;
            end
        end
        assign ch_req[c] = lvl_q;
        assign ch_ras[c] = ras_q;
        assign ch_eor[c] = eor_q;
    end
endmodule

// File: rtl/dreq_chan_map.sv
module dreq_chan_map
    import dcm_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [12:0]        addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic               map_err,
    input  logic [NUM_REQ-1:0] req_in,
    output logic [NUM_CH-1:0]  ch_req,
    output logic [NUM_CH-1:0]  ch_ras,
    output logic [NUM_CH-1:0]  ch_eor
);
    map_entry_t [NUM_REQ-1:0] map_w;
    logic [NUM_REQ-1:0]       lvl_w, chg_w;

    dcm_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .map_err(map_err), .map_out(map_w)
    );

    dcm_sync #(.NUM_REQ(NUM_REQ)) u_sync (
        .clk(clk), .rst(rst), .req_in(req_in), .lvl(lvl_w), .chg(chg_w)
    );

    dcm_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
        .clk(clk), .rst(rst), .map_in(map_w), .lvl(lvl_w), .chg(chg_w),
        .ch_req(ch_req), .ch_ras(ch_ras), .ch_eor(ch_eor)
    );
endmodule

// File: rtl/dreq_chan_map_chk.sv
module dreq_chan_map_chk
    import dcm_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [12:0]        addr,
    input logic [7:0]         wdata,
    input logic               map_err,
    input logic [NUM_CH-1:0]  ch_req,
    input logic [NUM_CH-1:0]  ch_ras,
    input logic [NUM_CH-1:0]  ch_eor
);
    logic bad_wr;
    assign bad_wr = wr_en && decode_addr(addr, NUM_REQ).hit
                    && chan_out_of_range(map_entry_t'(wdata), NUM_CH);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (ch_req == '0 && ch_ras == '0 && ch_eor == '0 && !map_err));

    assert_ras_with_level_R5: assert property (@(posedge clk) disable iff (rst)
        (ch_ras & ~ch_req) == '0);

    assert_eor_with_low_R6: assert property (@(posedge clk) disable iff (rst)
        (ch_eor & ch_req) == '0);

    assert_no_dual_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (ch_ras & ch_eor) == '0);

    assert_level_moves_with_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (ch_req ^ $past(ch_req)) == (ch_ras | ch_eor));

    assert_err_after_bad_write_R9: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> map_err);

    assert_err_only_after_write_R9: assert property (@(posedge clk) disable iff (rst)
        !bad_wr |=> !map_err);
endmodule

bind dreq_chan_map dreq_chan_map_chk #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .map_err(map_err), .ch_req(ch_req), .ch_ras(ch_ras), .ch_eor(ch_eor)
);

// File: tb/dreq_chan_map_tb.sv
module dreq_chan_map_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_REQ    = 75;
    localparam int NUM_CH     = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [12:0]        addr = '0;
    logic [7:0]         wdata = '0;
    logic [7:0]         rdata;
    logic               map_err;
    logic [NUM_REQ-1:0] req_in = '0;
    logic [NUM_CH-1:0]  ch_req, ch_ras, ch_eor;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0]         mdl_map [NUM_REQ];
    logic [NUM_REQ-1:0] cur_req = '0;
    logic [NUM_CH-1:0]  mdl_lvl = '0;
    logic [NUM_CH-1:0]  exp_lvl, exp_ras, exp_eor;

    dreq_chan_map #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .map_err(map_err), .req_in(req_in),
        .ch_req(ch_req), .ch_ras(ch_ras), .ch_eor(ch_eor)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [12:0] entry_addr(input int k);
        if (k < 64) return 13'(256 + 4 * k);
        return 13'(4352 + 4 * (k - 64));
    endfunction

    // Reference: ascending scan, last changing valid request per channel decides.
    task automatic predict(input logic [NUM_REQ-1:0] nv);
        logic [NUM_CH-1:0] hit, val;
        hit = '0; val = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (nv[i] != cur_req[i] && mdl_map[i][7] && int'(mdl_map[i][4:0]) < NUM_CH) begin
                hit[mdl_map[i][3:0]] = 1'b1;
                val[mdl_map[i][3:0]] = nv[i];
            end
        end
        exp_lvl = (mdl_lvl & ~hit) | (val & hit);
        exp_ras = hit & val & ~mdl_lvl;
        exp_eor = hit & ~val & mdl_lvl;
    endtask

    task automatic write_map(input logic [12:0] a, input logic [7:0] d, input int k);
        bit bad;
        bad = (k >= 0) && d[7] && (int'(d[4:0]) >= NUM_CH);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        check(map_err == bad, "R9", 32'(map_err), 32'(bad), "map_err after write");
        if (k >= 0 && !bad) mdl_map[k] = d;
        @(posedge clk); #1;
        check(map_err == 1'b0, "R9", 32'(map_err), 0, "map_err width");
    endtask

    task automatic read_entry(input int k, input string rq);
        @(negedge clk);
        addr = entry_addr(k);
        #1;
        check(rdata == mdl_map[k], rq, 32'(rdata), 32'(mdl_map[k]), $sformatf("entry %0d", k));
    endtask

    task automatic apply(input logic [NUM_REQ-1:0] nv, input string rq);
        logic [NUM_CH-1:0] old_lvl;
        predict(nv);
        old_lvl = mdl_lvl;
        @(negedge clk);
        req_in = nv;
        repeat (2) @(posedge clk);
        #1;
        check(ch_req == old_lvl && ch_ras == '0 && ch_eor == '0, "R5",
              32'(ch_req), 32'(old_lvl), "early edge unchanged");
        @(posedge clk); #1;
        check(ch_req == exp_lvl, rq, 32'(ch_req), 32'(exp_lvl), "ch_req");
        check(ch_ras == exp_ras, rq, 32'(ch_ras), 32'(exp_ras), "ch_ras");
        check(ch_eor == exp_eor, rq, 32'(ch_eor), 32'(exp_eor), "ch_eor");
        @(posedge clk); #1;
        check(ch_ras == '0 && ch_eor == '0 && ch_req == exp_lvl, "R7",
              32'(ch_ras | ch_eor), 0, "pulse one cycle");
        cur_req = nv;
        mdl_lvl = exp_lvl;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NUM_REQ-1:0] nv;
        void'($urandom(32'h1bad5eed));
        for (int k = 0; k < NUM_REQ; k++) mdl_map[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset state
        check(ch_req == '0 && ch_ras == '0 && ch_eor == '0, "R1", 32'(ch_req | ch_ras | ch_eor), 0, "channel outputs");
        check(map_err == 1'b0, "R1", 32'(map_err), 0, "map_err");
        for (int k = 0; k < NUM_REQ; k++) read_entry(k, "R1");

        // R2: unmapped addresses read 0, writes there store nothing
        @(negedge clk); addr = 13'h0FC; #1;
        check(rdata == '0, "R2", 32'(rdata), 0, "read 0x0FC");
        @(negedge clk); addr = 13'h101; #1;
        check(rdata == '0, "R2", 32'(rdata), 0, "read unaligned");
        write_map(13'h200, 8'h83, -1);
        write_map(13'h112C, 8'h81, -1);
        for (int k = 0; k < NUM_REQ; k++) read_entry(k, "R2");

        // R3: field layout and spare bits
        write_map(entry_addr(3), 8'h82, 3);
        write_map(entry_addr(5), 8'h02, 5);
        write_map(entry_addr(70), 8'hEF, 70);
        write_map(entry_addr(10), 8'h82, 10);
        write_map(entry_addr(63), 8'h61, 63);
        write_map(entry_addr(64), 8'h84, 64);
        read_entry(3, "R3"); read_entry(70, "R3"); read_entry(63, "R3"); read_entry(64, "R2");

        // R4: invalid entry ignored
        nv = cur_req; nv[5] = 1'b1; apply(nv, "R4");
        nv = cur_req; nv[63] = 1'b1; apply(nv, "R4");
        // R5/R6 single request
        nv = cur_req; nv[3] = 1'b1; apply(nv, "R5");
        nv = cur_req; nv[3] = 1'b0; apply(nv, "R6");
        nv = cur_req; nv[70] = 1'b1; apply(nv, "R5");
        nv = cur_req; nv[64] = 1'b1; apply(nv, "R5");
        // R7 shared channel 2 (requests 3 and 10)
        nv = cur_req; nv[3] = 1'b1; apply(nv, "R5");
        nv = cur_req; nv[10] = 1'b1; apply(nv, "R7");
        nv = cur_req; nv[3] = 1'b0; apply(nv, "R7");
        nv = cur_req; nv[3] = 1'b1; apply(nv, "R7");
        // R8: same-cycle opposite edges, request 10 falls while 3 falls too then mixed
        nv = cur_req; nv[3] = 1'b0; nv[10] = 1'b0; apply(nv, "R8");
        nv = cur_req; nv[3] = 1'b1; apply(nv, "R5");
        nv = cur_req; nv[3] = 1'b0; nv[10] = 1'b1; apply(nv, "R8");
        nv = cur_req; nv[3] = 1'b1; nv[10] = 1'b0; apply(nv, "R8");
        // R9: out-of-range channel refused
        write_map(entry_addr(3), 8'h94, 3);
        read_entry(3, "R9");
        write_map(entry_addr(74), 8'h9F, 74);
        read_entry(74, "R9");
        write_map(entry_addr(74), 8'h1F, 74);
        read_entry(74, "R3");

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            if ($urandom % 4 == 0) begin
                int k;
                logic [7:0] d;
                k = int'($urandom % NUM_REQ);
                d = {($urandom % 4) != 0, 2'($urandom), 5'($urandom % 20)};
                write_map(entry_addr(k), d, k);
                read_entry(k, "R9");
            end else begin
                nv = cur_req;
                for (int f = 0; f < 1 + int'($urandom % 5); f++) begin
                    int b;
                    b = int'($urandom % NUM_REQ);
                    nv[b] = ~nv[b];
                end
                apply(nv, "R8");
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule